// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the target side of a two-wire serial bus, answering at one fixed 7-bit address. It watches the bus clock and data lines through a synchroniser and finds START, repeated START and STOP conditions. It decodes the address byte and gives its acknowledge by pulling the data line low through an open-drain enable. A sixteen-entry byte register array sits behind an 8-bit register pointer.

A controller uses the block in combined format. It first writes one byte that loads the pointer, then either writes more bytes, each stored at the pointer, or issues a repeated START with the read bit and reads bytes back from the pointer. The pointer steps forward after each byte in both directions. A `busy_i` input lets the system hold the clock line low at the end of an acknowledge bit until it can go on.

Top module: `i2c_regtarget`

## Requirements
- R1: After reset both open-drain enables are inactive, so the data and clock lines are released.
- R2: An address byte is taken MSB first. If bits 7..1 equal the target address, the target pulls data low for the ninth clock as ACK (ack bit value 0). If they differ, the target leaves data released (value 1) and ignores the bus until the next START.
- R3: In a write, the first data byte loads the pointer and is acknowledged. Each later byte is stored at the pointer and acknowledged, and the pointer then increments, wrapping from 15 to 0.
- R4: A write byte while the pointer is 16 or above is NACKed and discarded. No register changes, and the pointer keeps its value.
- R5: In a read (address bit 0 = 1), the target shifts out the register at the pointer MSB first and then increments the pointer with the same wrap. The data enable changes only while the clock line is low, except when a START or STOP clears it.
- R6: The pointer keeps its value across a repeated START, so a write of the pointer followed by a repeated-START read returns that register.
- R7: After the controller NACKs a read byte, the target releases data and drives nothing until a START or STOP.
- R8: A START in the middle of a byte drops the partial byte, writes nothing, and returns the target to the address phase.
- R9: If `busy_i` is high on the clock fall that ends an acknowledge bit, the target holds the clock line low until `busy_i` falls. In a read, the byte to send is fetched when the hold is released.
- R10: A STOP releases both lines and keeps the register contents.
- R11: A read while the pointer is 16 or above returns 0xFF and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| busy_i | input | 1 | High while the system cannot accept or supply the next byte |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| scl_oe_o | output | 1 | When high, the clock line is pulled low (stretch) |

## Verification
The main function is tried with several transaction patterns. A plain write sequence and a combined-format read back show that bytes land at the pointer and that the pointer survives the repeated START. Pointers at 15 and at 16 or above separate the wrap from the out-of-range NACK and 0xFF paths. A foreign address and a START cut into the middle of a byte show that nothing is written in either case. Stretch probes in both directions show that the clock line really stays low and that read data is taken only when the hold is released.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDATA,
        PH_RDATA,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        phase_e              nxt;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   tx;
        logic [BYTE_W-1:0]   ptr;
        logic                ack_pend;
        logic                sda_oe;
        logic                hold;
    } eng_state_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] now_o,
    output logic [N_LINES-1:0] prev_o
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;
        logic              prev_q;
        logic              prev_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign now_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_ptr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_ptr_i,
    output logic [DW-1:0] rd_data_o
);

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic          hit;
        logic [DW-1:0] ent_d;

        always_comb begin
            hit   = wr_en_i && (wr_ptr_i == PW'(e));
            ent_d = hit ? wr_data_i : mem_q[e];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[e] <= '0;
            else        mem_q[e] <= ent_d;
        end
    end

    always_comb begin
        rd_data_o = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr_i == PW'(i)) rd_data_o = mem_q[i];
        end
    end

    // R4: the engine never asks for a store outside the array
    p_wr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (int'(wr_ptr_i) < DEPTH));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2A,
    parameter int         DEPTH       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_now,
    input  logic              scl_prev,
    input  logic              sda_now,
    input  logic              sda_prev,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_ptr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [BYTE_W-1:0] rd_ptr_o,
    output logic              sda_oe_o,
    output logic              scl_oe_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    eng_state_t st_q, st_d;

    logic start_ev, stop_ev, scl_rise, scl_fall, active, in_range;
    logic [BYTE_W-1:0] byte_in, ptr_inc, fetch;

    always_comb begin
        start_ev = scl_now && scl_prev && sda_prev && !sda_now;
        stop_ev  = scl_now && scl_prev && !sda_prev && sda_now;
        scl_rise = scl_now && !scl_prev;
        scl_fall = !scl_now && scl_prev;
        active   = (st_q.phase != PH_IDLE) && (st_q.phase != PH_WAIT);
        in_range = int'(st_q.ptr) < DEPTH;
        byte_in  = {st_q.shreg[BYTE_W-2:0], sda_now};
        ptr_inc  = (int'(st_q.ptr) == DEPTH - 1) ? '0 : st_q.ptr + 1'b1;
        fetch    = in_range ? rd_data_i : '1;
    end

    always_comb begin
        st_d      = st_q;
        wr_en_o   = 1'b0;
        wr_ptr_o  = st_q.ptr;
        wr_data_o = byte_in;

        if (start_ev || stop_ev) begin
            st_d.phase    = start_ev ? PH_ADDR : PH_IDLE;
            st_d.bit_cnt  = '0;
            st_d.sda_oe   = 1'b0;
            st_d.hold     = 1'b0;
            st_d.ack_pend = 1'b0;
        end else if (st_q.hold) begin
            if (!busy_i) begin
                st_d.hold = 1'b0;
                if (st_q.phase == PH_RDATA) begin
                    st_d.tx     = fetch;
                    st_d.sda_oe = !fetch[BYTE_W-1];
                    if (in_range) st_d.ptr = ptr_inc;
                end
            end
        end else if (scl_rise && active) begin
            if (st_q.bit_cnt < ACK_SLOT) begin
                st_d.shreg   = byte_in;
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                if (st_q.bit_cnt == LAST_BIT) begin
                    unique case (st_q.phase)
                        PH_ADDR: begin
                            if (byte_in[BYTE_W-1:1] == TARGET_ADDR) begin
                                st_d.ack_pend = 1'b1;
                                st_d.nxt      = byte_in[0] ? PH_RDATA : PH_PTR;
                            end else begin
                                st_d.phase   = PH_WAIT;
                                st_d.bit_cnt = '0;
                            end
                        end
                        PH_PTR: begin
                            st_d.ptr      = byte_in;
                            st_d.ack_pend = 1'b1;
                            st_d.nxt      = PH_WDATA;
                        end
                        PH_WDATA: begin
                            st_d.nxt = PH_WDATA;
                            if (in_range) begin
                                wr_en_o       = 1'b1;
                                st_d.ptr      = ptr_inc;
                                st_d.ack_pend = 1'b1;
                            end else begin
                                st_d.ack_pend = 1'b0;
                            end
                        end
                        default: begin
                            st_d.nxt      = PH_RDATA;
                            st_d.ack_pend = 1'b0;
                        end
                    endcase
                end
            end else begin
                st_d.bit_cnt = ACK_DONE;
                if (st_q.phase == PH_RDATA && sda_now) begin
                    st_d.phase   = PH_WAIT;
                    st_d.bit_cnt = '0;
                end
            end
        end else if (scl_fall && active) begin
            if (st_q.bit_cnt == ACK_SLOT) begin
                st_d.sda_oe = st_q.ack_pend;
            end else if (st_q.bit_cnt == ACK_DONE) begin
                st_d.bit_cnt  = '0;
                st_d.sda_oe   = 1'b0;
                st_d.ack_pend = 1'b0;
                st_d.phase    = st_q.nxt;
                if (busy_i) begin
                    st_d.hold = 1'b1;
                end else if (st_q.nxt == PH_RDATA) begin
                    st_d.tx     = fetch;
                    st_d.sda_oe = !fetch[BYTE_W-1];
                    if (in_range) st_d.ptr = ptr_inc;
                end
            end else if (st_q.phase == PH_RDATA && st_q.bit_cnt != '0) begin
                st_d.tx     = {st_q.tx[BYTE_W-2:0], 1'b0};
                st_d.sda_oe = !st_q.tx[BYTE_W-2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, nxt: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr_o = st_q.ptr;
    assign sda_oe_o = st_q.sda_oe;
    assign scl_oe_o = st_q.hold;

    // R8: any START puts the engine back at bit 0 of an address byte, line released
    p_start_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q.phase == PH_ADDR && st_q.bit_cnt == '0 && !st_q.sda_oe));

    // R5: data enable moves only while the clock line is low, bar START/STOP
    p_sda_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_now));

    // R9: a stretch ends one cycle after busy drops
    p_stretch_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !busy_i && !start_ev && !stop_ev) |=> !st_q.hold);

    // R10: STOP leaves both lines released
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_oe_o && !scl_oe_o));

    // R7: once out of the conversation the target drives nothing
    p_wait_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WAIT) |-> (!sda_oe_o && !scl_oe_o));

endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
    import i2ct_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2A,
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic busy_i,
    output logic sda_oe_o,
    output logic scl_oe_o
);

    localparam int LINES = 2;
    localparam int L_SCL = 1;
    localparam int L_SDA = 0;

    logic [LINES-1:0] ln_now, ln_prev;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_ptr, wr_data, rd_ptr, rd_data;

    i2ct_sync #(.N_LINES(LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .now_o  (ln_now),
        .prev_o (ln_prev)
    );

    i2ct_engine #(.TARGET_ADDR(TARGET_ADDR), .DEPTH(DEPTH)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_now   (ln_now[L_SCL]),
        .scl_prev  (ln_prev[L_SCL]),
        .sda_now   (ln_now[L_SDA]),
        .sda_prev  (ln_prev[L_SDA]),
        .busy_i    (busy_i),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_ptr_o  (wr_ptr),
        .wr_data_o (wr_data),
        .rd_ptr_o  (rd_ptr),
        .sda_oe_o  (sda_oe_o),
        .scl_oe_o  (scl_oe_o)
    );

    i2ct_regfile #(.DEPTH(DEPTH), .DW(BYTE_W), .PW(BYTE_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (wr_data),
        .rd_ptr_i  (rd_ptr),
        .rd_data_o (rd_data)
    );

endmodule

// File: tb/test_i2c_regtarget.sv
module test_i2c_regtarget;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] ADDR = 7'h2A;

    typedef struct { string tag; int val; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic sda_oe, scl_oe, scl_bus, sda_bus;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    exp_t exp_q[$];
    int   act_q[$];

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    always #(CLK_PERIOD/2) clk = !clk;

    i2c_regtarget #(.TARGET_ADDR(ADDR)) i_i2c_regtarget (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .busy_i(busy), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe)
    );

    function automatic void want(string tag, int v);
        exp_q.push_back('{tag, v});
    endfunction

    function automatic void got(int v);
        act_q.push_back(v);
    endfunction

    // monitor: pairs results with expectations in order
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t e;
            int   a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_chk++;
            if (a != e.val) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", e.tag, a, e.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_bus) tick(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        scl_up();         tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(Q);
        scl_up();         tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic probe_hold();
        m_scl_low = 1'b0;
        tick(30);
        want("R9 clock held low", 0); got(scl_bus);
        busy = 1'b0;
    endtask

    task automatic send_bit(input bit b, input bit probe);
        m_sda_low = !b; tick(Q);
        if (probe) probe_hold();
        scl_up(); tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic recv_bit(output bit b, input bit probe);
        m_sda_low = 1'b0; tick(Q);
        if (probe) probe_hold();
        scl_up(); tick(Q/2);
        b = sda_bus; tick(Q/2);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic wr(string tag, input logic [7:0] d, input int exp_ack, input bit probe = 0);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(d[i], probe && i == 7);
        recv_bit(a, 0);
        want(tag, exp_ack); got(a);
    endtask

    task automatic rd(string tag, input int exp_d, input bit mack, input bit probe = 0);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin
            bit b;
            recv_bit(b, probe && i == 7);
            d[i] = b;
        end
        send_bit(!mack, 0);
        want(tag, exp_d); got(d);
    endtask

    task automatic point(string tag, input logic [7:0] p);
        bus_start();
        wr({tag, " addr-w"}, {ADDR, 1'b0}, 0);
        wr({tag, " ptr"}, p, 0);
    endtask

    task automatic point_read(string tag, input logic [7:0] p);
        point(tag, p);
        bus_start();
        wr({tag, " addr-r"}, {ADDR, 1'b1}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1: lines released after reset
        want("R1 sda released", 0); got(sda_oe);
        want("R1 scl released", 0); got(scl_oe);

        // R3: pointer then two stores
        point("R3", 8'h03);
        wr("R3 data ack", 8'hA5, 0);
        wr("R3 data ack", 8'h3C, 0);
        bus_stop();
        tick(4);
        want("R10 lines free after stop", 0); got(sda_oe || scl_oe);

        // R6/R5: combined read back, master NACK on the last byte
        point_read("R6", 8'h03);
        rd("R5 R6 first byte", 8'hA5, 1);
        rd("R5 second byte", 8'h3C, 0);
        // R7: target now silent
        rd("R7 silent after nack", 8'hFF, 0);
        bus_stop();

        // R2: foreign address gets no ACK and the rest is ignored
        bus_start();
        wr("R2 foreign addr nack", {7'h15, 1'b0}, 1);
        wr("R2 ignored byte", 8'h00, 1);
        bus_stop();

        // R3 wrap 15 -> 0
        point("R3 wrap", 8'h0F);
        wr("R3 wrap store", 8'h11, 0);
        wr("R3 wrap store", 8'h22, 0);
        bus_stop();
        point_read("R5 wrap", 8'h0F);
        rd("R5 wrap reg15", 8'h11, 1);
        rd("R5 wrap reg0", 8'h22, 0);
        bus_stop();

        // R4/R11: out-of-range pointer
        point("R4", 8'h20);
        wr("R4 out of range nack", 8'h77, 1);
        bus_start();
        wr("R11 addr-r", {ADDR, 1'b1}, 0);
        rd("R11 reads FF", 8'hFF, 1);
        rd("R11 pointer unchanged", 8'hFF, 0);
        bus_stop();
        point_read("R4 nothing stored", 8'h00);
        rd("R4 reg0 intact", 8'h22, 0);
        bus_stop();

        // R8: START in the middle of a byte
        point("R8", 8'h07);
        send_bit(0, 0); send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
        bus_start();
        wr("R8 addr after abort", {ADDR, 1'b0}, 0);
        wr("R8 ptr", 8'h08, 0);
        wr("R8 store", 8'h5A, 0);
        bus_stop();
        point_read("R8 check", 8'h07);
        rd("R8 partial byte dropped", 8'h00, 1);
        rd("R8 later store", 8'h5A, 0);
        bus_stop();

        // R9: stretch on write
        point("R9 w", 8'h09);
        busy = 1'b1;
        wr("R9 store before hold", 8'h66, 0);
        wr("R9 store after hold", 8'h67, 0, 1);
        bus_stop();
        tick(4);
        want("R9 clock free", 0); got(scl_oe);

        // R9: stretch on read, byte fetched at release
        point("R9 r", 8'h09);
        bus_start();
        busy = 1'b1;
        wr("R9 addr-r", {ADDR, 1'b1}, 0);
        rd("R9 read after hold", 8'h66, 1, 1);
        rd("R9 next read", 8'h67, 0);
        bus_stop();

        tick(20);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule